// File: doc/BRIEF.md
# Serial Command Front End for a 13-Bit Converter

This block receives 16-bit command words over a three-wire serial link (chip select, serial clock, data in) and keeps the two code registers of a 13-bit converter: a staging register that software fills first, and a converter register whose value goes straight to the analog core through `dac_code`. The first three bits of each word select an operation and the remaining thirteen carry a code. The operation runs once, when chip select is released. All serial pins are sampled into the system clock domain, so the serial clock must run well below the system clock.

The block also keeps a general-purpose output pin and a setting that picks which serial clock edge moves `dout`. `dout` shows the most significant bit of the shift register. Two or more devices can share chip select and clock, with each `dout` feeding the next `din`. Shutdown and wake operations do not power anything down here. They become one-cycle strobes for a separate power controller. The serial link has no back-pressure. Every word that arrives complete is executed, and the block never stalls the sender.

Top module: `dacsif_top`

## Requirements
- R1: A word is shifted in MSB first on rising serial clock edges while `cs_n` is low. Bits [15:13] are the operation and bits [12:0] the code. Operation 001 writes the code to the staging register and leaves `dac_code` unchanged. `dac_code` changes only through an executed word, a clear or a reset.
- R2: Operation 010 writes the code to both registers and raises `wake_req` for exactly one clock cycle.
- R3: Operation 011 copies the staging register into `dac_code` and raises `wake_req` for exactly one clock cycle.
- R4: Operation 101 raises `shdn_req` for exactly one clock cycle and leaves both registers unchanged. `shdn_req` and `wake_req` are never high together, and each follows an executed word.
- R5: Operation 110 sets `upo` high and operation 100 sets it low. Operation 000 changes neither `upo` nor `dac_code`.
- R6: Operation 111 with bit 12 set selects rising-edge output mode. With bits [12:11] = 00 it selects falling-edge output mode, which is the mode after reset. With bits [12:11] = 01 the mode is left unchanged.
- R7: A word executes only if the number of rising serial clock edges in its chip-select-low frame is a nonzero multiple of 16, and then the last 16 bits are used. Other frames have no effect. Serial clock edges while `cs_n` is high shift nothing.
- R8: While `rst_n` or `clr_n` is low, both registers load 0x1000 if `rst_mid` is 1 and 0x0000 if it is 0, and `upo` goes low. Clear takes priority over a word that executes in the same cycle.
- R9: In falling-edge mode, `dout` takes the new shift-register MSB after each falling serial clock edge. A chain of two devices clocked with a 32-edge frame therefore leaves the first 16 bits sent in the far device.
- R10: In rising-edge mode, `dout` takes the new MSB right after each rising serial clock edge, which is half a serial clock earlier than in falling-edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on clk |
| clr_n | input | 1 | Active-low clear to the reset code, sampled on clk |
| rst_mid | input | 1 | Reset code select: 1 = midscale, 0 = zero |
| cs_n | input | 1 | Active-low serial chip select (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous) |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out, MSB of the shift register |
| dac_code | output | 13 | Converter register value |
| upo | output | 1 | General-purpose output pin |
| shdn_req | output | 1 | One-cycle shutdown request strobe |
| wake_req | output | 1 | One-cycle wake request strobe |

## Verification
A rise on `cs_n` passes through two synchronizer flops and one edge register, so `dac_code`, `upo` and the strobes change on the fourth `clk` edge after the rise. The bench waits twelve cycles before it checks any of these registered values. `dout` follows a synchronized serial clock edge by about three cycles, so the bench samples it on the last system cycle of each eight-cycle serial half period. A scoreboard queue holds each expected new value of `dac_code`. The monitor takes one entry every time the output changes, so a change that comes early, late or when none was expected is caught. Strobes are counted by the monitor and compared after each frame.

// File: rtl/dacsif_pkg.sv
`timescale 1ns/1ps
package dacsif_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    OP_NOP       = 3'b000,
    OP_LOAD_STG  = 3'b001,
    OP_LOAD_BOTH = 3'b010,
    OP_XFER      = 3'b011,
    OP_UPO_LO    = 3'b100,
    OP_SLEEP     = 3'b101,
    OP_UPO_HI    = 3'b110,
    OP_CFG       = 3'b111
  } op_e;
endpackage

// File: rtl/dacsif_sync.sv
`timescale 1ns/1ps
module dacsif_sync #(
  parameter int           N      = 1,
  parameter int           STAGES = 2,
  parameter logic [N-1:0] IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] synced
);
  genvar b;
  generate
    for (b = 0; b < N; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{IDLE[b]}};
        else        chain <= {chain[STAGES-2:0], raw[b]};
      end
      assign synced[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dacsif_shifter.sv
`timescale 1ns/1ps
module dacsif_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lo,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic              mode_rise,
  output logic [WORD_W-1:0] word,
  output logic              exec_v,
  output logic              dout
);
  localparam int POS_W = $clog2(WORD_W);
  localparam logic [POS_W-1:0] LAST = POS_W'(WORD_W - 1);

  logic             sclk_d, cs_d, wrapped;
  logic [POS_W-1:0] pos;
  logic             sclk_up, sclk_dn, frame_start, frame_end;
  logic [WORD_W-1:0] sr_next;

  assign sclk_up     =  sclk_s & ~sclk_d;
  assign sclk_dn     = ~sclk_s &  sclk_d;
  assign frame_start =  cs_lo  & ~cs_d;
  assign frame_end   = ~cs_lo  &  cs_d;
  assign sr_next     = {word[WORD_W-2:0], din_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b0;
      word    <= '0;
      pos     <= '0;
      wrapped <= 1'b0;
      exec_v  <= 1'b0;
      dout    <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_lo;
      // a frame counts only if it ended on a whole-word boundary
      exec_v <= frame_end && wrapped && (pos == '0);
      if (frame_start) begin
        pos     <= '0;
        wrapped <= 1'b0;
      end else if (cs_lo && sclk_up) begin
        word <= sr_next;
        if (pos == LAST) begin
          pos     <= '0;
          wrapped <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
        if (mode_rise) dout <= sr_next[WORD_W-1];
      end else if (cs_lo && sclk_dn && !mode_rise) begin
        dout <= word[WORD_W-1];
      end
    end
  end
endmodule

// File: rtl/dacsif_regs.sv
`timescale 1ns/1ps
module dacsif_regs
  import dacsif_pkg::*;
#(
  parameter int DATA_W = 13,
  localparam int WORD_W = CMD_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              rst_mid,
  input  logic              exec_v,
  input  logic [WORD_W-1:0] word,
  output logic [DATA_W-1:0] dac_code,
  output logic              upo,
  output logic              mode_rise,
  output logic              shdn_req,
  output logic              wake_req
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] stg_q, rst_code, code;
  op_e               op;

  assign rst_code = rst_mid ? MID : '0;
  assign op       = op_e'(word[WORD_W-1 -: CMD_W]);
  assign code     = word[DATA_W-1:0];

  always_ff @(posedge clk) begin
    shdn_req <= 1'b0;
    wake_req <= 1'b0;
    if (!rst_n || !clr_n) begin
      stg_q    <= rst_code;
      dac_code <= rst_code;
      upo      <= 1'b0;
      if (!rst_n) mode_rise <= 1'b0;
    end else if (exec_v) begin
      unique case (op)
        OP_LOAD_STG:  stg_q <= code;
        OP_LOAD_BOTH: begin
          stg_q    <= code;
          dac_code <= code;
          wake_req <= 1'b1;
        end
        OP_XFER: begin
          dac_code <= stg_q;
          wake_req <= 1'b1;
        end
        OP_UPO_LO:    upo      <= 1'b0;
        OP_SLEEP:     shdn_req <= 1'b1;
        OP_UPO_HI:    upo      <= 1'b1;
        OP_CFG: begin
          if (code[DATA_W-1])      mode_rise <= 1'b1;
          else if (!code[DATA_W-2]) mode_rise <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dacsif_top.sv
`timescale 1ns/1ps
module dacsif_top
  import dacsif_pkg::*;
#(
  parameter int DATA_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              rst_mid,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic [DATA_W-1:0] dac_code,
  output logic              upo,
  output logic              shdn_req,
  output logic              wake_req
);
  localparam int WORD_W = CMD_W + DATA_W;

  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word;
  logic              exec_v, mode_rise;

  // order {din, sclk, cs_n}; idle levels 0, 0, 1
  dacsif_sync #(.N(3), .STAGES(SYNC_STAGES), .IDLE(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({din, sclk, cs_n}), .synced(pins_s)
  );

  dacsif_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_lo(~pins_s[0]), .sclk_s(pins_s[1]),
    .din_s(pins_s[2]), .mode_rise(mode_rise), .word(word),
    .exec_v(exec_v), .dout(dout)
  );

  dacsif_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .rst_mid(rst_mid),
    .exec_v(exec_v), .word(word), .dac_code(dac_code), .upo(upo),
    .mode_rise(mode_rise), .shdn_req(shdn_req), .wake_req(wake_req)
  );
endmodule

// File: rtl/dacsif_chk.sv
`timescale 1ns/1ps
module dacsif_chk #(
  parameter int DATA_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              rst_mid,
  input logic              exec_v,
  input logic [DATA_W-1:0] dac_code,
  input logic              upo,
  input logic              shdn_req,
  input logic              wake_req
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shdn_req, wake_req}));

  p_sleep_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_req |=> !shdn_req);

  p_sleep_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_req |-> $past(exec_v));

  p_wake_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  p_dac_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clr_n) && !$past(exec_v)) |-> $stable(dac_code));

  p_upo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clr_n) && !$past(exec_v)) |-> $stable(upo));

  p_clear_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> ((dac_code == ($past(rst_mid) ? MID : '0)) && !upo));
endmodule

bind dacsif_top dacsif_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .rst_mid(rst_mid),
  .exec_v(exec_v), .dac_code(dac_code), .upo(upo),
  .shdn_req(shdn_req), .wake_req(wake_req)
);

// File: tb/dacsif_top_tb_top.sv
`timescale 1ns/1ps
module dacsif_top_tb_top;
  localparam int HALF = 8;   // system cycles per serial half period
  localparam int GAP  = 12;

  logic clk = 1'b0, rst_n = 1'b0, clr_n = 1'b1, rst_mid = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout, upo, shdn_req, wake_req;
  logic [12:0] dac_code;
  logic dout_b, upo_b, shdn_b, wake_b;
  logic [12:0] dac_b;

  int total = 0, fails = 0, shdn_cnt = 0, wake_cnt = 0;
  bit mon_on = 1'b0, done = 1'b0;
  logic [12:0] last_dac;
  logic [12:0] exp_q[$];

  always #2.5 clk = ~clk;

  dacsif_top dut_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .rst_mid(rst_mid),
    .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout), .dac_code(dac_code),
    .upo(upo), .shdn_req(shdn_req), .wake_req(wake_req)
  );

  // far device of a two-deep chain
  dacsif_top dut_b (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .rst_mid(1'b0),
    .cs_n(cs_n), .sclk(sclk), .din(dout), .dout(dout_b), .dac_code(dac_b),
    .upo(upo_b), .shdn_req(shdn_b), .wake_req(wake_b)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // chk: 0 none, 1 falling-edge mode expected, 2 rising-edge mode expected
  task automatic frame(input logic [31:0] bits, input int n, input int chk,
                       input logic [15:0] prev);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < n; i++) begin
      din = bits[n-1-i];
      tick(HALF);
      sclk = 1'b1;
      tick(HALF - 1);
      if (chk == 2 && i < 15) check("R10 dout rising mode", 32'(dout), 32'(prev[14-i]));
      if (chk == 1 && i < 15) check("R9 dout falling mode", 32'(dout), 32'(prev[15-i]));
      tick(1);
      sclk = 1'b0;
    end
    tick(HALF);
    cs_n = 1'b1;
    tick(GAP);
  endtask

  task automatic word16(input logic [15:0] w);
    frame({16'h0, w}, 16, 0, 16'h0);
  endtask

  // scoreboard monitor for dac_code and strobe counter
  always @(negedge clk) begin
    if (mon_on) begin
      if (dac_code !== last_dac) begin
        total++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R1 dac_code changed unexpectedly: actual 0x%0h expected 0x%0h",
                   dac_code, last_dac);
        end else begin
          logic [12:0] e;
          e = exp_q.pop_front();
          if (e !== dac_code) begin
            fails++;
            $display("FAIL R1 dac_code scoreboard: actual 0x%0h expected 0x%0h", dac_code, e);
          end
        end
        last_dac = dac_code;
      end
      if (shdn_req) shdn_cnt++;
      if (wake_req) wake_cnt++;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R8 reset state with midscale selected
    check("R8 reset dac_code", 32'(dac_code), 32'h1000);
    check("R8 reset upo", 32'(upo), 32'h0);
    check("R4 reset strobes", 32'({shdn_req, wake_req}), 32'h0);
    check("R9 reset dout", 32'(dout), 32'h0);
    last_dac = dac_code;
    mon_on = 1'b1;

    // R1 staging load only
    word16(16'h2555);
    check("R1 dac unchanged after staging load", 32'(dac_code), 32'h1000);
    // R3 transfer
    exp_q.push_back(13'h0555);
    word16(16'h6000);
    check("R3 wake strobe count", 32'(wake_cnt), 32'd1);
    // R2 load both
    exp_q.push_back(13'h1FFF);
    word16(16'h5FFF);
    check("R2 wake strobe count", 32'(wake_cnt), 32'd2);
    // R4 shutdown request
    word16(16'hA123);
    check("R4 shutdown strobe count", 32'(shdn_cnt), 32'd1);
    check("R4 dac unchanged", 32'(dac_code), 32'h1FFF);
    // R5 user output and no-op
    word16(16'hC000);
    check("R5 upo high", 32'(upo), 32'h1);
    word16(16'h1234);
    check("R5 nop keeps upo", 32'(upo), 32'h1);
    word16(16'h8000);
    check("R5 upo low", 32'(upo), 32'h0);

    // R7 partial and over-long frames are ignored
    frame({20'h0, 12'h4AA}, 12, 0, 16'h0);
    frame({15'h0, 17'h04AAA}, 17, 0, 16'h0);
    check("R7 partial frames ignored", 32'(dac_code), 32'h1FFF);
    check("R7 no stray strobes", 32'(wake_cnt), 32'd2);
    // clocks with cs_n high shift nothing
    din = 1'b1;
    for (int k = 0; k < 8; k++) begin
      tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
    end
    din = 1'b0;
    word16(16'h2321);
    exp_q.push_back(13'h0321);
    word16(16'h6000);
    check("R7 word intact after idle clocks", 32'(dac_code), 32'h0321);

    // R8 clear with zero then midscale selection
    word16(16'hC000);
    rst_mid = 1'b0;
    exp_q.push_back(13'h0000);
    clr_n = 1'b0; tick(2); clr_n = 1'b1; tick(2);
    check("R8 clear to zero", 32'(dac_code), 32'h0);
    check("R8 clear drops upo", 32'(upo), 32'h0);
    exp_q.push_back(13'h0777);
    word16(16'h4777);
    rst_mid = 1'b1;
    exp_q.push_back(13'h1000);
    clr_n = 1'b0; tick(2); clr_n = 1'b1; tick(2);
    word16(16'h6000);
    check("R8 staging register cleared to midscale", 32'(dac_code), 32'h1000);

    // R6 and R10 output edge selection
    word16(16'hF000);
    word16(16'h1A5B);
    frame(32'h0, 16, 2, 16'h1A5B);
    word16(16'hE800);                  // bits 12:11 = 01 leave mode alone
    word16(16'h1A5B);
    frame(32'h0, 16, 2, 16'h1A5B);     // R6 mode unchanged
    word16(16'hE000);
    word16(16'h13C6);
    frame(32'h0, 16, 1, 16'h13C6);     // R6 back to falling mode

    // R9 chain of two devices, 32-edge frame
    frame(32'h4ABC_2123, 32, 0, 16'h0);
    check("R9 far device got first word", 32'(dac_b), 32'h0ABC);
    check("R9 near device dac unchanged", 32'(dac_code), 32'h1000);
    exp_q.push_back(13'h0123);
    word16(16'h6000);
    check("R9 near device got second word", 32'(dac_code), 32'h0123);

    tick(4);
    check("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule